// File: doc/BRIEF.md
# Copy Engine Control and Status Registers

This block is the register file and sequencing logic for a memory-to-memory copy engine that moves one block per command. Software reaches it through an AXI4-Lite slave port with 32-bit data. It holds a source address, a destination address and a byte count, and it hands these to a separate datapath together with a one-cycle start pulse. Writing the byte count is what starts a copy; there is no separate go bit.

The block shows whether a copy is running through an idle bit. When the datapath finishes, the block records either a completion or one of three error kinds in sticky flags. Software clears each flag by writing a one to its bit. Each flag has its own enable bit, and the two enabled flags are combined onto a single level interrupt.

Top module: `copy_ctl_regs`

## Requirements
- R1: After reset, control, source, destination and length read as zero, status reads 0x0000_0002 (only the idle bit 1 set), irq is low and xfer_start is low.
- R2: A write of a nonzero value to the length register at offset 0x28 while idle stores its low 23 bits and, in the cycle after the write handshake, raises xfer_start for exactly one cycle with xfer_src, xfer_dst and xfer_len equal to the stored source (0x18), destination (0x20) and length. The status idle bit reads 0 from then on until the copy ends.
- R3: A write of a length whose low 23 bits are zero stores the zero and starts nothing: xfer_start stays low and idle stays 1.
- R4: While idle is 0, writes to the source, destination and length registers change nothing: their read values and the outputs stay as they were.
- R5: A datapath done pulse with code 0 while busy returns idle to 1 and sets the completion flag, status bit 12.
- R6: A done pulse with a nonzero code while busy returns idle to 1 and sets the error flag, status bit 14, together with one detail bit. Code 1 (internal) sets bit 4, code 2 (slave) sets bit 5 and code 3 (decode) sets bit 6. The completion flag is not set.
- R7: Writing status with bit 12 set clears the completion flag. Writing status with bit 14 set clears the error flag and all three detail bits. Zero bits in the written value leave the flags unchanged. A flag event in the same cycle as its clear leaves the flag set.
- R8: irq is high exactly when (status bit 12 and control bit 12) or (status bit 14 and control bit 14) hold.
- R9: Only control bits 12 and 14 are writable, and the other control bits read 0. The length reads back as its 23 bits zero-extended. Offsets with no register read 0. Every write and read response is OKAY (2'b00). Writes always replace the whole 32-bit word.
- R10: A write is accepted on a cycle where awvalid and wvalid are both high and no write response is pending. A read is accepted when arvalid is high and no read data is pending. bvalid and rvalid rise in the cycle after acceptance and hold, with rdata stable, until the matching ready is high.
- R11: A done pulse while idle has no effect on any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | ADDR_W | Write address (byte offset) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_araddr | input | ADDR_W | Read address (byte offset) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data taken |
| xfer_start | output | 1 | One-cycle start pulse to the datapath |
| xfer_src | output | 32 | Source address of the copy |
| xfer_dst | output | 32 | Destination address of the copy |
| xfer_len | output | LEN_W | Byte count of the copy |
| xfer_done | input | 1 | Datapath finished pulse |
| xfer_err | input | 2 | Completion code with done: 0 ok, 1 internal, 2 slave, 3 decode |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the datapath raises xfer_done only as a single-cycle pulse and that xfer_err is meaningful only in that cycle. They also assume that the master keeps addresses and data steady while valid is high. The bench drives done strictly as one-cycle pulses, some during a copy and some while idle. It presents address and data on the same falling edge, except for one case where the data trails the address by a few cycles. That case tests acceptance under R10 without breaking the stability assumption.

// File: rtl/copy_ctl_regs.sv
module copy_ctl_regs #(
  parameter int ADDR_W = 6,
  parameter int LEN_W  = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              xfer_start,
  output logic [31:0]       xfer_src,
  output logic [31:0]       xfer_dst,
  output logic [LEN_W-1:0]  xfer_len,
  input  logic              xfer_done,
  input  logic [1:0]        xfer_err,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFS_CTL  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFS_SRC  = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] OFS_DST  = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] OFS_LEN  = ADDR_W'('h28);
  localparam int BIT_DONE = 12;
  localparam int BIT_ERR  = 14;

  logic             en_done, en_err, flag_done, flag_err, busy, start_q;
  logic [2:0]       err_det;
  logic [31:0]      src_q, dst_q, stat_word, ctl_word, rd_mux;
  logic [LEN_W-1:0] len_q;

  wire wr_fire = s_awvalid & s_wvalid & ~s_bvalid;
  wire rd_fire = s_arvalid & ~s_rvalid;
  wire wr_ctl  = wr_fire & (s_awaddr == OFS_CTL);
  wire wr_stat = wr_fire & (s_awaddr == OFS_STAT);
  wire wr_src  = wr_fire & (s_awaddr == OFS_SRC) & ~busy;
  wire wr_dst  = wr_fire & (s_awaddr == OFS_DST) & ~busy;
  wire wr_len  = wr_fire & (s_awaddr == OFS_LEN) & ~busy;
  wire [LEN_W-1:0] new_len = s_wdata[LEN_W-1:0];
  wire go      = wr_len & (new_len != '0);
  wire fin     = busy & xfer_done;
  wire fin_ok  = fin & (xfer_err == 2'd0);
  wire fin_bad = fin & (xfer_err != 2'd0);

  assign s_awready  = wr_fire;
  assign s_wready   = wr_fire;
  assign s_arready  = ~s_rvalid;
  assign s_bresp    = 2'b00;
  assign s_rresp    = 2'b00;
  assign xfer_start = start_q;
  assign xfer_src   = src_q;
  assign xfer_dst   = dst_q;
  assign xfer_len   = len_q;
  assign irq        = (flag_done & en_done) | (flag_err & en_err);

  assign stat_word = {17'b0, flag_err, 1'b0, flag_done, 5'b0, err_det, 2'b0, ~busy, 1'b0};
  assign ctl_word  = (32'(en_err) << BIT_ERR) | (32'(en_done) << BIT_DONE);

  always_comb begin
    case (s_araddr)
      OFS_CTL:  rd_mux = ctl_word;
      OFS_STAT: rd_mux = stat_word;
      OFS_SRC:  rd_mux = src_q;
      OFS_DST:  rd_mux = dst_q;
      OFS_LEN:  rd_mux = 32'(len_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_bvalid <= 1'b0;
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
    end else begin
      if (wr_fire) s_bvalid <= 1'b1;
      else if (s_bready) s_bvalid <= 1'b0;
      if (rd_fire) begin
        s_rvalid <= 1'b1;
        s_rdata  <= rd_mux;
      end else if (s_rready) s_rvalid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_done <= 1'b0;
      en_err  <= 1'b0;
      src_q   <= '0;
      dst_q   <= '0;
      len_q   <= '0;
      busy    <= 1'b0;
      start_q <= 1'b0;
    end else begin
      if (wr_ctl) begin
        en_done <= s_wdata[BIT_DONE];
        en_err  <= s_wdata[BIT_ERR];
      end
      if (wr_src) src_q <= s_wdata;
      if (wr_dst) dst_q <= s_wdata;
      if (wr_len) len_q <= new_len;
      start_q <= go;
      if (go) busy <= 1'b1;
      else if (fin) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_done <= 1'b0;
      flag_err  <= 1'b0;
      err_det   <= '0;
    end else begin
      if (fin_ok) flag_done <= 1'b1;
      else if (wr_stat && s_wdata[BIT_DONE]) flag_done <= 1'b0;
      if (fin_bad) begin
        flag_err <= 1'b1;
        err_det  <= (wr_stat && s_wdata[BIT_ERR]) ? 3'b000 : err_det;
        err_det[xfer_err - 2'd1] <= 1'b1;
      end else if (wr_stat && s_wdata[BIT_ERR]) begin
        flag_err <= 1'b0;
        err_det  <= '0;
      end
    end
  end

  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> stat_word[1] == 1'b0);
  assert_frozen_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_done) |=> $stable(xfer_src) && $stable(xfer_dst) && $stable(xfer_len));
  assert_ok_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_done && xfer_err == 2'd0) |=> flag_done && !busy);
  assert_err_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_done && xfer_err != 2'd0) |=> flag_err && $countones(err_det) >= 1 && !busy);
  assert_bhold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid && !s_bready) |=> s_bvalid);
  assert_rhold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> s_rvalid && $stable(s_rdata));
  assert_idle_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go) |=> $stable(flag_err) || $fell(flag_err));
endmodule

// File: tb/sim_copy_ctl_regs.sv
module sim_copy_ctl_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] awaddr = '0, araddr = '0;
  logic awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1;
  logic [31:0] wdata = '0;
  logic xfer_done = 0;
  logic [1:0] xfer_err = '0;
  logic awready, wready, bvalid, arready, rvalid, xfer_start, irq;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata, xfer_src, xfer_dst;
  logic [22:0] xfer_len;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  copy_ctl_regs u0 (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .xfer_start(xfer_start), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
    .xfer_len(xfer_len), .xfer_done(xfer_done), .xfer_err(xfer_err), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_en_d, m_en_e, m_df, m_ef, m_busy, m_start, m_bv, m_rv;
  bit [2:0] m_det;
  logic [31:0] m_src, m_dst, m_rd;
  logic [22:0] m_len;

  function automatic logic [31:0] m_read(input logic [5:0] a);
    case (a)
      6'h00: return {17'b0, m_en_e, 1'b0, m_en_d, 12'b0};
      6'h04: return {17'b0, m_ef, 1'b0, m_df, 5'b0, m_det, 2'b0, !m_busy, 1'b0};
      6'h18: return m_src;
      6'h20: return m_dst;
      6'h28: return {9'b0, m_len};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_en_d, m_en_e, m_df, m_ef, m_busy, m_start, m_bv, m_rv} = '0;
      m_det = '0; m_src = '0; m_dst = '0; m_len = '0; m_rd = '0;
    end else begin
      bit was_busy, aw_acc, ar_acc, go;
      was_busy = m_busy;
      aw_acc = awvalid && wvalid && !m_bv;
      ar_acc = arvalid && !m_rv;
      go = 0;
      if (ar_acc) m_rd = m_read(araddr);
      if (aw_acc) begin
        case (awaddr)
          6'h00: begin m_en_d = wdata[12]; m_en_e = wdata[14]; end
          6'h04: begin
            if (wdata[12]) m_df = 0;
            if (wdata[14]) begin m_ef = 0; m_det = '0; end
          end
          6'h18: if (!was_busy) m_src = wdata;
          6'h20: if (!was_busy) m_dst = wdata;
          6'h28: if (!was_busy) begin m_len = wdata[22:0]; go = (wdata[22:0] != 0); end
          default: ;
        endcase
      end
      if (was_busy && xfer_done) begin
        m_busy = 0;
        if (xfer_err == 0) m_df = 1;
        else begin m_ef = 1; m_det[xfer_err - 1] = 1; end
      end
      if (go) m_busy = 1;
      m_start = go;
      if (aw_acc) m_bv = 1; else if (bready) m_bv = 0;
      if (ar_acc) m_rv = 1; else if (rready) m_rv = 0;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R2 xfer_start", xfer_start, m_start);
    if (m_start) begin
      chk("R2 xfer_src", xfer_src, m_src);
      chk("R2 xfer_dst", xfer_dst, m_dst);
      chk("R2 xfer_len", xfer_len, m_len);
    end
    chk("R8 irq", irq, (m_df & m_en_d) | (m_ef & m_en_e));
    chk("R10 bvalid", bvalid, m_bv);
    chk("R10 rvalid", rvalid, m_rv);
    if (rvalid) begin chk("R9 rdata", rdata, m_rd); chk("R9 rresp", rresp, 0); end
    if (bvalid) chk("R9 bresp", bresp, 0);
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    awaddr = a; wdata = d; awvalid = 1; wvalid = 1;
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    while (bvalid) @(negedge clk);
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    araddr = a; arvalid = 1;
    @(negedge clk);
    arvalid = 0; d = rdata;
    while (rvalid) @(negedge clk);
  endtask

  task automatic done_pulse(input logic [1:0] code);
    @(negedge clk);
    xfer_done = 1; xfer_err = code;
    @(negedge clk);
    xfer_done = 0; xfer_err = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    chk("R1 irq reset", irq, 0);
    chk("R1 start reset", xfer_start, 0);
    rst_n = 1;
    rd(6'h04, v); chk("R1 status reset", v, 32'h2);
    rd(6'h00, v); chk("R1 ctl reset", v, 0);
    rd(6'h28, v); chk("R1 len reset", v, 0);

    wr(6'h18, 32'h1000_0004);
    wr(6'h20, 32'h2000_0008);
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, v); chk("R9 ctl writable bits", v, 32'h0000_5000);

    wr(6'h28, 32'h0);
    rd(6'h04, v); chk("R3 zero length stays idle", v, 32'h2);

    wr(6'h28, 32'h0000_0100);
    rd(6'h04, v); chk("R2 busy after start", v, 32'h0);
    wr(6'h18, 32'hDEAD_BEEF);
    wr(6'h28, 32'h5);
    rd(6'h18, v); chk("R4 src frozen", v, 32'h1000_0004);
    rd(6'h28, v); chk("R4 len frozen", v, 32'h100);

    done_pulse(2'd0);
    rd(6'h04, v); chk("R5 completion flag", v, 32'h1002);
    chk("R8 irq on completion", irq, 1);
    wr(6'h04, 32'h0000_4000);
    rd(6'h04, v); chk("R7 wrong bit keeps flag", v, 32'h1002);
    wr(6'h04, 32'h0000_1000);
    rd(6'h04, v); chk("R7 completion cleared", v, 32'h2);

    for (int c = 1; c <= 3; c++) begin
      wr(6'h28, 32'h007F_FFFF);
      done_pulse(2'(c));
      rd(6'h04, v); chk("R6 error detail", v, 32'h4002 | (32'h1 << (3 + c)));
      wr(6'h04, 32'h0000_4000);
      rd(6'h04, v); chk("R7 error cleared", v, 32'h2);
    end

    done_pulse(2'd2);
    rd(6'h04, v); chk("R11 done while idle ignored", v, 32'h2);

    wr(6'h00, 32'h0);
    wr(6'h28, 32'hFF80_0003);
    rd(6'h28, v); chk("R9 len 23 bits", v, 32'h3);
    done_pulse(2'd0);
    chk("R8 masked irq low", irq, 0);
    wr(6'h00, 32'h0000_1000);
    chk("R8 irq after enable", irq, 1);
    wr(6'h04, 32'h0000_1000);

    rd(6'h0C, v); chk("R9 undefined 0x0C", v, 0);
    rd(6'h30, v); chk("R9 undefined 0x30", v, 0);

    // address before data, response held off by bready
    @(negedge clk);
    awaddr = 6'h18; awvalid = 1; bready = 0;
    repeat (3) @(negedge clk);
    wdata = 32'hCAFE_0000; wvalid = 1;
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    repeat (3) @(negedge clk);
    chk("R10 bvalid held", bvalid, 1);
    bready = 1;
    @(negedge clk);
    rd(6'h18, v); chk("R10 late data write", v, 32'hCAFE_0000);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule